// File: doc/BRIEF.md
# DMA Request Sense and Hold Stage

This block sits between an external DMA request pin and one channel of a DMA controller. It resynchronises the pin into the controller clock domain, then decides from a 2-bit trigger-select code whether the pin is treated as an edge event or as a level. In either case the result is held in a single request flag. Software can read the flag, and the channel arbiter sees it.

In the two edge modes, the first matching edge seen at a sampling point sets the flag. The flag then stays set whatever the pin does, and more edges are dropped, not queued. Only the channel's acknowledge strobe clears it. In the two level modes, the flag is refreshed at each sampling point while the pin is at its active level. A requester that does not withdraw its level before the next sampling point after an acknowledge therefore gets another transfer. The channel state machine drives `sample_en_i` to mark the sampling points.

Top module: `dma_req_detect`

## Requirements
- R1: After reset (asynchronous, active low) `req_flag_o` and `req_o` are 0, and asserting reset at any time clears the flag at once.
- R2: With trigger code 2'b00 (falling-edge sensing), a 1-to-0 transition of `req_pin_i` sets `req_flag_o` on the third rising clock edge after the pin change, when `sample_en_i` is high. A 0-to-1 transition does not set it.
- R3: With trigger code 2'b10 (rising-edge sensing), a 0-to-1 transition of `req_pin_i` sets `req_flag_o` with the same three-edge latency, and a 1-to-0 transition does not set it.
- R4: In the edge modes, a set flag keeps its value regardless of the later level of `req_pin_i`, until an acknowledge or a mode change.
- R5: In the edge modes, further selected edges that arrive while the flag is set are ignored. One acknowledge clears the flag, and it stays 0 with no replay of the dropped edges.
- R6: `ack_i` high at a rising edge clears the flag at that edge unless a new request is sensed in the same cycle. `req_o` equals the flag masked by `ack_i`, so it is 0 during an acknowledge cycle.
- R7: If a selected edge is sensed in the same cycle as `ack_i`, the current request is consumed and the flag stays 1 for the new edge.
- R8: The pin is only evaluated when `sample_en_i` is high. An edge that occurs while `sample_en_i` is low does not set the flag then, but it is detected at the next cycle in which `sample_en_i` is high.
- R9: With trigger code 2'b01 (low-level sensing), the flag is set at a sampling point where the synchronised pin is 0. After an acknowledge, the flag is set again if the pin is still low, and it stays 0 once the pin has gone high.
- R10: With trigger code 2'b11 (high-level sensing), the flag follows the same rules as R9 with the pin polarity inverted.
- R11: A change of `trig_sel_i` clears the flag on the next edge. The edge history is reloaded from the current pin, so the switch itself raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_sel_i | input | 2 | Trigger code: 00 falling, 01 low level, 10 rising, 11 high level |
| req_pin_i | input | 1 | Raw, asynchronous DMA request pin |
| sample_en_i | input | 1 | Sampling point strobe from the channel state machine |
| ack_i | input | 1 | Request accepted and acknowledge issued |
| req_flag_o | output | 1 | Held request flag, software readable |
| req_o | output | 1 | Request to the channel arbiter |

## Verification
The hardest situations to reach from the ports are an edge landing in the very cycle of an acknowledge, and an edge that falls between sampling points. Both depend on the pin change being placed exactly two synchroniser stages ahead of the strobe. The stimulus table therefore schedules each pin transition by counting the two-flop delay. It places an acknowledge on the cycle in which the resynchronised falling edge meets the edge history, and it holds `sample_en_i` low across a falling edge and raises it two cycles later. Mode switches are made while the pin sits at the level that a stale history would misread as an edge.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  localparam int unsigned TRIG_W = 2;

  typedef enum logic [TRIG_W-1:0] {
    TRIG_FALL = 2'b00,
    TRIG_LOW  = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_HIGH = 2'b11
  } trig_mode_e;
endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= 1'b0;
        else         stage_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= 1'b0;
        else         stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/dma_req_sense.sv
module dma_req_sense
  import dma_req_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TRIG_W-1:0] trig_sel_i,
  input  logic              pin_sync_i,
  input  logic              sample_en_i,
  output logic              hit_o,
  output logic              mode_chg_o
);
  trig_mode_e mode_q;
  logic       hist_q;
  logic       cond;

  assign mode_chg_o = (trig_sel_i != mode_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= TRIG_FALL;
    else         mode_q <= trig_mode_e'(trig_sel_i);
  end

  // history advances only at sampling points, so an edge between samples is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         hist_q <= 1'b0;
    else if (mode_chg_o || sample_en_i)  hist_q <= pin_sync_i;
  end

  always_comb begin
    unique case (trig_mode_e'(trig_sel_i))
      TRIG_FALL: cond = hist_q & ~pin_sync_i;
      TRIG_RISE: cond = ~hist_q & pin_sync_i;
      TRIG_LOW:  cond = ~pin_sync_i;
      TRIG_HIGH: cond = pin_sync_i;
      default:   cond = 1'b0;
    endcase
  end

  assign hit_o = sample_en_i & ~mode_chg_o & cond;

  a_r8_no_hit_off_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_en_i |-> !hit_o);
endmodule

// File: rtl/dma_req_latch.sv
module dma_req_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic ack_i,
  input  logic mode_chg_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;

  // ack consumes the pending request; a same-cycle hit re-arms it
  always_comb begin
    if (mode_chg_i) flag_d = 1'b0;
    else            flag_d = (flag_q & ~ack_i) | hit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  a_r4_flag_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !ack_i && !mode_chg_i |=> flag_q);
  a_r6_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !hit_i |=> !flag_q);
  a_r7_ack_and_hit_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && hit_i |=> flag_q);
endmodule

// File: rtl/dma_req_detect.sv
module dma_req_detect
  import dma_req_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TRIG_W-1:0] trig_sel_i,
  input  logic              req_pin_i,
  input  logic              sample_en_i,
  input  logic              ack_i,
  output logic              req_flag_o,
  output logic              req_o
);
  logic pin_sync;
  logic hit;
  logic mode_chg;
  logic flag;

  dma_req_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (req_pin_i),
    .q_o    (pin_sync)
  );

  dma_req_sense i_sense (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trig_sel_i  (trig_sel_i),
    .pin_sync_i  (pin_sync),
    .sample_en_i (sample_en_i),
    .hit_o       (hit),
    .mode_chg_o  (mode_chg)
  );

  dma_req_latch i_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_i      (hit),
    .ack_i      (ack_i),
    .mode_chg_i (mode_chg),
    .flag_o     (flag)
  );

  assign req_flag_o = flag;
  assign req_o      = flag & ~ack_i;

  a_r11_mode_change_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg |=> !req_flag_o);
  a_r8_idle_without_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_en_i && !req_flag_o |=> !req_flag_o);
endmodule

// File: tb/test_dma_req_detect.sv
module test_dma_req_detect;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] trig_sel_i = 2'b00;
  logic       req_pin_i = 1'b0;
  logic       sample_en_i = 1'b0;
  logic       ack_i = 1'b0;
  logic       req_flag_o;
  logic       req_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  dma_req_detect i_dma_req_detect (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trig_sel_i  (trig_sel_i),
    .req_pin_i   (req_pin_i),
    .sample_en_i (sample_en_i),
    .ack_i       (ack_i),
    .req_flag_o  (req_flag_o),
    .req_o       (req_o)
  );

  // {req id, trig code, pin, sample, ack, expected flag after the edge}
  function automatic logic [9:0] mk(input int rid, input logic [1:0] sel,
                                    input logic pin, input logic smp,
                                    input logic ack, input logic exp_f);
    return {rid[3:0], sel, pin, smp, ack, exp_f};
  endfunction

  localparam int N_VEC = 51;
  localparam logic [9:0] VEC [N_VEC] = '{
    mk(2,2'b00,1,1,0,0), mk(2,2'b00,1,1,0,0), mk(2,2'b00,0,1,0,0), mk(2,2'b00,0,1,0,0), // R2 rise ignored
    mk(2,2'b00,1,1,0,1),                                                             // R2 fall sets
    mk(4,2'b00,0,1,0,1), mk(4,2'b00,1,1,0,1),                                        // R4 hold
    mk(5,2'b00,1,1,0,1), mk(6,2'b00,1,1,1,0), mk(5,2'b00,1,1,0,0), mk(5,2'b00,0,1,0,0), // R5 R6
    mk(8,2'b00,0,0,0,0), mk(8,2'b00,0,0,0,0), mk(8,2'b00,0,0,0,0), mk(8,2'b00,0,1,0,1), // R8 late sample
    mk(4,2'b00,1,1,0,1), mk(4,2'b00,0,1,0,1), mk(4,2'b00,0,1,0,1),
    mk(7,2'b00,0,1,1,1), mk(6,2'b00,0,1,1,0), mk(6,2'b00,0,1,0,0),                    // R7 edge+ack
    mk(11,2'b10,0,1,0,0), mk(3,2'b10,1,1,0,0), mk(3,2'b10,1,1,0,0), mk(3,2'b10,0,1,0,1), // R3
    mk(4,2'b10,0,1,0,1), mk(4,2'b10,0,1,0,1), mk(6,2'b10,0,1,1,0), mk(6,2'b10,0,1,0,0),
    mk(3,2'b10,1,1,0,0), mk(3,2'b10,1,1,0,0), mk(3,2'b10,1,1,0,1),
    mk(11,2'b00,1,1,0,0), mk(11,2'b00,1,1,0,0),                                      // R11 clear, no spurious
    mk(11,2'b01,1,1,0,0), mk(9,2'b01,0,1,0,0), mk(9,2'b01,0,1,0,0), mk(9,2'b01,0,1,0,1), // R9
    mk(9,2'b01,0,1,1,1), mk(9,2'b01,1,1,1,1), mk(9,2'b01,1,1,0,1), mk(9,2'b01,1,1,1,0),
    mk(9,2'b01,1,1,0,0),
    mk(11,2'b11,1,1,0,0), mk(10,2'b11,1,1,0,1), mk(10,2'b11,0,1,1,1), mk(10,2'b11,0,1,0,1), // R10
    mk(10,2'b11,0,1,1,0), mk(10,2'b11,0,1,0,0), mk(10,2'b11,0,0,0,0),
    mk(11,2'b00,0,1,0,0)
  };

  task automatic check(input string tag, input logic act, input logic exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp_v, $time);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=complete");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check("R1 flag in reset", req_flag_o, 1'b0);
    check("R1 req in reset", req_o, 1'b0);
    rst_ni = 1'b1;
    sample_en_i = 1'b1;
    step();
    step();
    check("R1 flag after reset", req_flag_o, 1'b0);

    for (int i = 0; i < N_VEC; i++) begin
      logic [9:0] v;
      v = VEC[i];
      trig_sel_i  = v[5:4];
      req_pin_i   = v[3];
      sample_en_i = v[2];
      ack_i       = v[1];
      step();
      check($sformatf("R%0d row %0d flag", v[9:6], i), req_flag_o, v[0]);
      check($sformatf("R%0d row %0d req (R6 mask)", v[9:6], i), req_o, v[0] & ~v[1]);
    end

    // R1: reset clears a pending request immediately
    ack_i = 1'b0; sample_en_i = 1'b1; trig_sel_i = 2'b00;
    req_pin_i = 1'b1; repeat (3) step();
    req_pin_i = 1'b0; repeat (3) step();
    check("R2 directed flag set", req_flag_o, 1'b1);
    rst_ni = 1'b0;
    #1;
    check("R1 async reset flag", req_flag_o, 1'b0);
    check("R1 async reset req", req_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) step();
    check("R1 idle after reset release", req_flag_o, 1'b0);

    done = 1'b1;
    finish_run();
  end
endmodule